// File: doc/BRIEF.md
# Two-Step Line Table Write Port

This block is the register-side port of a per-line lookup table used by a graphics address translator. The table holds 1024 entries of 35 bits. Each entry packs a line-enable bit, a first and a last mapped block number of 8 bits each, and an 18-bit line offset. A 32-bit bus cannot write such an entry in one access, so every entry appears as two bus words.

A write to the low word of an entry does not touch the table. It only loads a staging register with the enable bit and the two block numbers. A write to the high word supplies the line offset, and the table is written once with the staged fields and that offset together. Readback of either word always shows what the table holds, never the staging register.

The table has a single port, shared by bus accesses and by translation lookups. A table write wins over a lookup in the same cycle, and a lookup wins over a bus read. The losing side sees its ready signal low and is served in a later cycle.

Top module: `lut_wport`

## Requirements
- R1: A write to the low word of entry x, at byte offset 0x1000 + 8x, changes no table entry. A later readback of any entry returns the table contents as they were.
- R2: A write to the high word of entry x, at offset 0x1004 + 8x, stores into entry x the staged enable, first-block and last-block fields together with the line offset taken from write-data bits [21:4]. Both words of entry x then read back the new values.
- R3: The low word reads back as follows: the last mapped block in bits [23:16], the first mapped block in bits [15:8], and the enable bit in bit 0. Every other bit reads zero, and the same bits are ignored on write.
- R4: The high word reads back with the line offset in bits [21:4]. Every other bit reads zero, and the same bits are ignored on write.
- R5: The staging register is zero after reset and keeps its value after a commit. A high-word write that follows no fresh low-word write commits whatever the staging register holds.
- R6: When a high-word write and a lookup request occur in the same cycle, the write is performed and lk_ready is low. The lookup is served in a later cycle and returns the newly written entry.
- R7: When a bus read of the table and a lookup request occur in the same cycle, the lookup is served and bus_ready is low. The read completes in a later cycle.
- R8: A low-word write never stalls a lookup, and lk_ready stays high in that cycle.
- R9: A lookup accepted in a cycle (lk_req and lk_ready both high) raises lk_valid in the next cycle. lk_en, lk_first, lk_last and lk_offs then carry the fields of entry lk_line.
- R10: A bus read accepted in a cycle (bus_req and bus_ready high, bus_we low) raises bus_rvalid in the next cycle, with the read word on bus_rdata.
- R11: Bus accesses below 0x1000 or at 0x3000 and above are accepted at once. A write there has no effect, and a read there returns zero.
- R12: After reset, bus_rvalid and lk_valid are low, and bus_ready and lk_ready are high while nothing competes for the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | Bus access is a write |
| bus_addr | input | 14 | Byte offset of the bus access |
| bus_wdata | input | 32 | Bus write data |
| bus_ready | output | 1 | Bus access accepted this cycle |
| bus_rvalid | output | 1 | Read data valid (one cycle after acceptance) |
| bus_rdata | output | 32 | Read data |
| lk_req | input | 1 | Lookup request |
| lk_line | input | 10 | Line index to look up |
| lk_ready | output | 1 | Lookup accepted this cycle |
| lk_valid | output | 1 | Lookup result valid |
| lk_en | output | 1 | Line enable of looked-up entry |
| lk_first | output | 8 | First mapped block of looked-up entry |
| lk_last | output | 8 | Last mapped block of looked-up entry |
| lk_offs | output | 18 | Line offset of looked-up entry |

## Verification
The bench targets the staging path first. It writes a low word and then reads the table back; a design that wrote the table on the low word would show the new fields too early. It also commits high words without a fresh low word; a design that cleared the staging register after each commit would read back zeros. It drives each of the two same-cycle collisions. A design with the priorities swapped would return the old entry to the colliding lookup, or would stall the lookup instead of the bus read. Reserved bits and out-of-window addresses are written with all ones, so any leak of reserved bits, or any aliasing into the table, shows up as nonzero readback.

// File: rtl/lut_wport.sv
module lut_wport #(
  parameter int ENTRIES = 1024,
  parameter int AW = 14,
  parameter logic [AW-1:0] BASE = 14'h1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic          bus_ready,
  output logic          bus_rvalid,
  output logic [31:0]   bus_rdata,
  input  logic          lk_req,
  input  logic [$clog2(ENTRIES)-1:0] lk_line,
  output logic          lk_ready,
  output logic          lk_valid,
  output logic          lk_en,
  output logic [7:0]    lk_first,
  output logic [7:0]    lk_last,
  output logic [17:0]   lk_offs
);
  localparam int IW = $clog2(ENTRIES);
  localparam int SW = 17;
  localparam int EW = SW + 18;
  localparam int SPAN = ENTRIES * 8;

  logic [EW-1:0] mem [ENTRIES];
  logic [SW-1:0] stage_q;
  logic [EW-1:0] rd_q;
  logic          rd_hi_q, rd_tbl_q;

  logic [AW-1:0] rel;
  logic          in_tbl, is_hi, ram_we, lo_we, rd_gnt, lk_gnt;
  logic [IW-1:0] idx, rd_idx;

  assign rel    = bus_addr - BASE;
  assign in_tbl = (bus_addr >= BASE) && (int'(rel) < SPAN);
  assign idx    = rel[IW+2:3];
  assign is_hi  = bus_addr[2];

  assign ram_we = bus_req && bus_we && in_tbl && is_hi;
  assign lo_we  = bus_req && bus_we && in_tbl && !is_hi;
  assign lk_gnt = lk_req && !ram_we;
  assign rd_gnt = bus_req && !bus_we && in_tbl && !lk_req;

  assign lk_ready  = !ram_we;
  assign bus_ready = !(bus_req && !bus_we && in_tbl && lk_req);
  assign rd_idx    = lk_gnt ? lk_line : idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stage_q <= '0;
    else if (lo_we) stage_q <= {bus_wdata[0], bus_wdata[15:8], bus_wdata[23:16]};

  always_ff @(posedge clk)
    if (ram_we) mem[idx] <= {stage_q, bus_wdata[21:4]};

  always_ff @(posedge clk)
    if (lk_gnt || rd_gnt) rd_q <= mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lk_valid   <= 1'b0;
      bus_rvalid <= 1'b0;
      rd_hi_q    <= 1'b0;
      rd_tbl_q   <= 1'b0;
    end else begin
      lk_valid   <= lk_gnt;
      bus_rvalid <= bus_req && !bus_we && bus_ready;
      rd_hi_q    <= is_hi;
      rd_tbl_q   <= in_tbl;
    end

  assign lk_en    = rd_q[EW-1];
  assign lk_first = rd_q[EW-2 -: 8];
  assign lk_last  = rd_q[EW-10 -: 8];
  assign lk_offs  = rd_q[17:0];

  assign bus_rdata = !(bus_rvalid && rd_tbl_q) ? 32'h0 :
                     rd_hi_q ? {10'h0, lk_offs, 4'h0} :
                               {8'h0, lk_last, lk_first, 7'h0, lk_en};

  p_lk_stall_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !lk_ready) |-> (bus_req && bus_we && bus_addr[2]));
  p_rd_stall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |-> (lk_req && lk_ready && !bus_we));
  p_lo_nostall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lo_we |-> lk_ready);
  p_lk_served_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && lk_ready) |=> lk_valid);
  p_rd_served_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ready && !bus_we) |=> bus_rvalid);
  p_single_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_we, lk_gnt, rd_gnt}));
endmodule

// File: tb/test_lut_wport.sv
module test_lut_wport;
  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_we = 0, lk_req = 0;
  logic [13:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [9:0] lk_line = 0;
  logic bus_ready, bus_rvalid, lk_ready, lk_valid, lk_en;
  logic [7:0] lk_first, lk_last;
  logic [17:0] lk_offs;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  lut_wport i_lut_wport (.*);

  localparam int NV = 20;
  localparam logic [46:0] VEC [NV] = '{
    {1'b1, 14'h102C, 32'hFFFF_FFFF},
    {1'b0, 14'h1028, 32'h0000_0000},
    {1'b0, 14'h102C, 32'h003F_FFF0},
    {1'b1, 14'h1000, 32'hFFA5_3C81},
    {1'b0, 14'h102C, 32'h003F_FFF0},
    {1'b0, 14'h1028, 32'h0000_0000},
    {1'b1, 14'h1004, 32'h0012_3450},
    {1'b0, 14'h1000, 32'h00A5_3C01},
    {1'b0, 14'h1004, 32'h0012_3450},
    {1'b1, 14'h1FFC, 32'hC000_0000},
    {1'b0, 14'h1FF8, 32'h00A5_3C01},
    {1'b0, 14'h1FFC, 32'h0000_0000},
    {1'b1, 14'h2FF8, 32'h00FF_0001},
    {1'b1, 14'h2FFC, 32'h003F_FFF0},
    {1'b0, 14'h2FF8, 32'h00FF_0001},
    {1'b1, 14'h3000, 32'hFFFF_FFFF},
    {1'b0, 14'h3000, 32'h0000_0000},
    {1'b1, 14'h0FFC, 32'hFFFF_FFFF},
    {1'b0, 14'h0FFC, 32'h0000_0000},
    {1'b0, 14'h2FFC, 32'h003F_FFF0}
  };
  localparam string VTAG [NV] = '{"R5","R5","R4","R1","R1","R1","R2","R3","R4",
    "R5","R5","R4","R3","R2","R3","R11","R11","R11","R11","R11"};

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input bit we, input logic [13:0] a, input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    #1;
    while (!bus_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    rd = bus_rdata;
    bus_req = 0; bus_we = 0;
  endtask

  initial begin
    #(20ns * 200000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1;
    check(!bus_rvalid && !lk_valid, "R12 valid", {bus_rvalid, lk_valid}, 0);
    check(bus_ready && lk_ready, "R12 ready", {bus_ready, lk_ready}, 3);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      bus_op(VEC[i][46], VEC[i][45:32], VEC[i][31:0], r);
      if (!VEC[i][46]) begin
        check(bus_rvalid, {VTAG[i], " R10 rvalid"}, bus_rvalid, 1);
        check(r == VEC[i][31:0], VTAG[i], r, VEC[i][31:0]);
      end
    end

    // R6: high write on entry 2 collides with lookup of line 2
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 14'h1014; bus_wdata = 32'h0000_0AB0;
    lk_req = 1; lk_line = 10'd2;
    #1;
    check(!lk_ready, "R6 lk_ready", lk_ready, 0);
    check(bus_ready, "R6 bus_ready", bus_ready, 1);
    @(posedge clk); #1;
    bus_req = 0; bus_we = 0;
    check(!lk_valid, "R6 no early result", lk_valid, 0);
    #1;
    check(lk_ready, "R6 ready after", lk_ready, 1);
    @(posedge clk); #1;
    lk_req = 0;
    check(lk_valid, "R9 lk_valid", lk_valid, 1);
    check(lk_en && lk_first == 8'h00 && lk_last == 8'hFF && lk_offs == 18'h000AB,
          "R6 new entry", {lk_en, lk_first, lk_last, 5'h0, lk_offs[9:0]}, {1'b1, 8'h00, 8'hFF, 15'h0AB});

    // R7: lookup of line 0 beats bus read of entry 1023 high
    @(negedge clk);
    lk_req = 1; lk_line = 10'd0;
    bus_req = 1; bus_we = 0; bus_addr = 14'h2FFC;
    #1;
    check(!bus_ready, "R7 bus_ready", bus_ready, 0);
    check(lk_ready, "R7 lk_ready", lk_ready, 1);
    @(posedge clk); #1;
    lk_req = 0;
    check(lk_valid && !bus_rvalid, "R7 order", {lk_valid, bus_rvalid}, 2);
    check(lk_en && lk_first == 8'h3C && lk_last == 8'hA5 && lk_offs == 18'h12345,
          "R9 fields", {lk_first, lk_last, 14'h0, lk_en}, {8'h3C, 8'hA5, 15'h1});
    #1;
    check(bus_ready, "R7 released", bus_ready, 1);
    @(posedge clk); #1;
    bus_req = 0;
    check(bus_rvalid && bus_rdata == 32'h003F_FFF0, "R7 late read", bus_rdata, 32'h003F_FFF0);

    // R8: low write alongside lookup
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 14'h1010; bus_wdata = 32'h0011_2201;
    lk_req = 1; lk_line = 10'd1023;
    #1;
    check(lk_ready, "R8 lk_ready", lk_ready, 1);
    @(posedge clk); #1;
    bus_req = 0; bus_we = 0; lk_req = 0;
    check(lk_valid && lk_last == 8'hFF, "R8 lookup served", lk_last, 8'hFF);
    bus_op(0, 14'h1010, 0, r);
    check(r == 32'h00FF_0001, "R1 entry2 low unchanged", r, 32'h00FF_0001);
    bus_op(1, 14'h1014, 32'h0000_0010, r);
    bus_op(0, 14'h1010, 0, r);
    check(r == 32'h0011_2201, "R2 staged commit", r, 32'h0011_2201);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule